// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast input clock by a ratio whose average is INT + FRAC/MOD. A down-counter counts input clock edges and raises a one-cycle output pulse at the end of each division cycle. A first-order accumulator picks the length of the next cycle, either INT or INT+1. Over MOD consecutive cycles it chooses the longer length exactly FRAC times, so the average ratio carries a fractional part.

Software sets the ratio through a byte-wide write port. Writes to the numerator, the denominator and the upper integer nibble only load staging registers. Writing the integer low byte commits the whole staged set at once. The new set takes over at the next output pulse, so the cycle already running always finishes at its old length. A commit that breaks a range rule raises a sticky error flag. The set is still applied, with the numerator clamped to one below the denominator.

Top module: `fracn_feedback_divider`

## Requirements
- R1: The staged fields reset to zero and read back on `cfg_rdata` for the address on `cfg_addr`. Numerator bits 17:16 are at address 0x01 bits 1:0, bits 15:8 at 0x02 and bits 7:0 at 0x03. The denominator uses the same layout at 0x04, 0x05 and 0x06. Integer bits 11:8 are at 0x07 bits 3:0 and bits 7:0 at 0x08. Unused bits read as zero.
- R2: A write to an address outside 0x01 to 0x08 changes no register, and such an address reads as zero.
- R3: Writes to 0x01 to 0x07 leave the running division unchanged. A write to 0x08 commits the staged numerator, denominator and integer together, using the written byte as integer bits 7:0.
- R4: After reset no pulse appears until the first commit. The first pulse then appears INT clock cycles after the commit edge.
- R5: A commit made while the divider runs takes effect at the next output pulse. The cycle in progress keeps its old length. The accumulator is cleared at that point, so the first new cycle lasts INT.
- R6: With an active numerator of zero, every division cycle lasts exactly INT clock cycles.
- R7: With a non-zero numerator F and denominator M, cycle j after the switch (j ≥ 1) lasts INT+1 when floor(j·F/M) > floor((j−1)·F/M), and INT otherwise. Over any M consecutive cycles, exactly F of them last INT+1.
- R8: `cfg_error` rises on a commit with FRAC ≥ MOD, MOD < 2, INT < 35 or INT > 4091. It stays high until reset. Legal commits never raise it.
- R9: If a committed numerator is not below the denominator, the divider uses MOD−1 in its place.
- R10: `div_pulse` is high for a single clock cycle per division cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Register address for both write and readback |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Staged register contents at `cfg_addr` |
| div_pulse | output | 1 | One-cycle pulse at the end of each division cycle |
| cfg_error | output | 1 | Sticky flag for an out-of-range commit |

## Verification
Two cases are hard to reach from the ports. One is a commit that arrives while a division cycle is half done. The other is the same commit landing in the exact cycle in which the output pulse is visible. The bench logs the cycle of every pulse and the cycle of every commit, so it can find the boundary pulse whichever way the two line up. It then checks the old cycle's length, and the new cycles one by one against the floor formula. The sweep runs through every legal numerator for denominators 2 to 6. It also covers both integer bounds and a numerator that needs clamping.

// File: rtl/fracn_feedback_divider.sv
module fracn_feedback_divider #(
  parameter int unsigned INT_MIN = 35,
  parameter int unsigned INT_MAX = 4091,
  parameter int unsigned MOD_MIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       div_pulse,
  output logic       cfg_error
);
  localparam int FW = 18;
  localparam int IW = 12;
  localparam int CW = IW + 1;
  localparam logic [7:0] A_FH = 8'h01, A_FM = 8'h02, A_FL = 8'h03;
  localparam logic [7:0] A_MH = 8'h04, A_MM = 8'h05, A_ML = 8'h06;
  localparam logic [7:0] A_IH = 8'h07, A_IL = 8'h08;

  logic [FW-1:0] stg_frac, stg_mod;
  logic [3:0]    stg_int_hi;
  logic [7:0]    stg_int_lo;

  logic [FW-1:0] pend_frac, pend_mod;
  logic [IW-1:0] pend_int;
  logic          pend_v;

  logic [FW-1:0] act_frac, act_mod, acc_q;
  logic [IW-1:0] act_int;
  logic [CW-1:0] cnt_q;
  logic          running_q;
  logic          err_q;

  wire           commit  = cfg_wr && (cfg_addr == A_IL);
  wire [IW-1:0]  cm_int  = {stg_int_hi, cfg_wdata};
  wire [FW-1:0]  cm_mod  = stg_mod;
  wire           cm_over = (stg_frac >= cm_mod);
  wire [FW-1:0]  cm_frac = !cm_over ? stg_frac : (cm_mod == '0) ? '0 : cm_mod - FW'(1);
  wire           cm_bad  = cm_over || (cm_mod < FW'(MOD_MIN)) ||
                           (cm_int < IW'(INT_MIN)) || (cm_int > IW'(INT_MAX));

  assign div_pulse = running_q && (cnt_q == '0);
  assign cfg_error = err_q;

  wire           take_new = commit ? (!running_q || div_pulse) : (div_pulse && pend_v);
  wire [FW-1:0]  src_frac = commit ? cm_frac : pend_frac;
  wire [FW-1:0]  src_mod  = commit ? cm_mod  : pend_mod;
  wire [IW-1:0]  src_int  = commit ? cm_int  : pend_int;

  wire [FW:0]    sum   = {1'b0, acc_q} + {1'b0, act_frac};
  wire           carry = (act_frac != '0) && (sum >= {1'b0, act_mod});
  wire [FW-1:0]  acc_n = carry ? FW'(sum - {1'b0, act_mod}) : sum[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_frac   <= '0;
      stg_mod    <= '0;
      stg_int_hi <= '0;
      stg_int_lo <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        A_FH: stg_frac[17:16] <= cfg_wdata[1:0];
        A_FM: stg_frac[15:8]  <= cfg_wdata;
        A_FL: stg_frac[7:0]   <= cfg_wdata;
        A_MH: stg_mod[17:16]  <= cfg_wdata[1:0];
        A_MM: stg_mod[15:8]   <= cfg_wdata;
        A_ML: stg_mod[7:0]    <= cfg_wdata;
        A_IH: stg_int_hi      <= cfg_wdata[3:0];
        A_IL: stg_int_lo      <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      A_FH:    cfg_rdata = {6'b0, stg_frac[17:16]};
      A_FM:    cfg_rdata = stg_frac[15:8];
      A_FL:    cfg_rdata = stg_frac[7:0];
      A_MH:    cfg_rdata = {6'b0, stg_mod[17:16]};
      A_MM:    cfg_rdata = stg_mod[15:8];
      A_ML:    cfg_rdata = stg_mod[7:0];
      A_IH:    cfg_rdata = {4'b0, stg_int_hi};
      A_IL:    cfg_rdata = stg_int_lo;
      default: cfg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_frac <= '0;
      pend_mod  <= '0;
      pend_int  <= '0;
      pend_v    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (commit) begin
        pend_frac <= cm_frac;
        pend_mod  <= cm_mod;
        pend_int  <= cm_int;
        if (cm_bad) err_q <= 1'b1;
      end
      if (take_new)    pend_v <= 1'b0;
      else if (commit) pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_frac  <= '0;
      act_mod   <= '0;
      act_int   <= '0;
      acc_q     <= '0;
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (take_new) begin
      act_frac  <= src_frac;
      act_mod   <= src_mod;
      act_int   <= src_int;
      acc_q     <= '0;
      cnt_q     <= {1'b0, src_int} - CW'(1);
      running_q <= 1'b1;
    end else if (div_pulse) begin
      if (act_frac != '0) acc_q <= acc_n;
      cnt_q <= carry ? {1'b0, act_int} : {1'b0, act_int} - CW'(1);
    end else if (running_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/fracn_div_checker.sv
module fracn_div_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        div_pulse,
  input logic        cfg_error,
  input logic        running_q,
  input logic [17:0] acc_q,
  input logic [17:0] act_mod,
  input logic [11:0] act_int,
  input logic [17:0] stg_frac
);
  assert_stage_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'h03) |=> (stg_frac[7:0] == $past(cfg_wdata)));

  assert_no_pulse_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !div_pulse);

  assert_acc_below_mod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod != '0) |-> (acc_q < act_mod));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && $past(div_pulse) && $past(rst_n)) |-> (act_int < 12'd2));
endmodule

bind fracn_feedback_divider fracn_div_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .div_pulse(div_pulse), .cfg_error(cfg_error),
  .running_q(running_q), .acc_q(acc_q), .act_mod(act_mod),
  .act_int(act_int), .stg_frac(stg_frac)
);

// File: tb/fracn_feedback_divider_tb_top.sv
`timescale 1ns/1ps
module fracn_feedback_divider_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       div_pulse;
  logic       cfg_error;

  int checks = 0, errors = 0;
  int cyc = 0, np = 0;
  int pcyc [0:1023];
  int wc = 0, np_at = 0, bi = 0;

  fracn_feedback_divider dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .div_pulse(div_pulse),
    .cfg_error(cfg_error)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (div_pulse && np < 1024) begin
      pcyc[np] = cyc;
      np = np + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    wc = cyc; np_at = np;
    @(negedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    cfg_addr = a; #1;
    v = cfg_rdata;
  endtask

  task automatic stage(input int f, input int m, input int i);
    wr(8'h01, 8'((f >> 16) & 3));
    wr(8'h02, 8'((f >> 8) & 255));
    wr(8'h03, 8'(f & 255));
    wr(8'h04, 8'((m >> 16) & 3));
    wr(8'h05, 8'((m >> 8) & 255));
    wr(8'h06, 8'(m & 255));
    wr(8'h07, 8'((i >> 8) & 15));
  endtask

  task automatic load(input int f, input int m, input int i);
    stage(f, m, i);
    wr(8'h08, 8'(i & 255));
    bi = (np_at > 0 && pcyc[np_at-1] == wc) ? np_at - 1 : np_at;
  endtask

  task automatic wait_np(input int k);
    while (np < k) begin @(negedge clk); #2; end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  // R7/R9: check cycles j=0..m after boundary bi using effective numerator fe
  task automatic check_pattern(input int fe, input int m, input int i, input string req);
    int longs;
    longs = 0;
    wait_np(bi + m + 2);
    for (int j = 0; j <= m; j++) begin
      int g, e;
      g = pcyc[bi+1+j] - pcyc[bi+j];
      e = i + ((j == 0) ? 0 : (j * fe) / m - ((j - 1) * fe) / m);
      chk(g == e, req, g, e);
      if (j > 0 && g == i + 1) longs++;
    end
    chk(longs == fe, req, longs, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int g;
    do_reset();
    // R1 reset state
    chk(div_pulse == 0, "R4 reset pulse", div_pulse, 0);
    chk(cfg_error == 0, "R8 reset error", cfg_error, 0);
    for (int a = 1; a <= 8; a++) begin
      rd(8'(a), v);
      chk(v == 0, "R1 reset readback", v, 0);
    end
    // R1 masks
    wr(8'h01, 8'hFF); rd(8'h01, v); chk(v == 8'h03, "R1 frac hi mask", v, 3);
    wr(8'h04, 8'hFE); rd(8'h04, v); chk(v == 8'h02, "R1 mod hi mask", v, 2);
    wr(8'h07, 8'hFF); rd(8'h07, v); chk(v == 8'h0F, "R1 int hi mask", v, 15);
    wr(8'h05, 8'hA5); rd(8'h05, v); chk(v == 8'hA5, "R1 mod mid", v, 165);
    // R2 unmapped
    wr(8'h20, 8'h77); rd(8'h20, v); chk(v == 0, "R2 unmapped read", v, 0);
    rd(8'h05, v); chk(v == 8'hA5, "R2 unmapped no effect", v, 165);
    wr(8'h00, 8'h33); rd(8'h03, v); chk(v == 0, "R2 addr0 no effect", v, 0);
    // R4 no pulse before commit
    repeat (60) @(negedge clk);
    chk(np == 0, "R4 idle no pulse", np, 0);
    // R4 first pulse INT after commit
    load(0, 5, 40);
    wait_np(np_at + 1);
    chk(pcyc[np_at] - wc == 40, "R4 first pulse", pcyc[np_at] - wc, 40);
    // R6 integer mode
    wait_np(np_at + 5);
    for (int k = np_at + 1; k < np_at + 5; k++) begin
      g = pcyc[k] - pcyc[k-1];
      chk(g == 40, "R6 integer period", g, 40);
    end
    // R3 staging alone does not change division
    wr(8'h03, 8'h02);
    g = np;
    wait_np(g + 4);
    for (int k = g + 1; k < g + 4; k++) begin
      chk(pcyc[k] - pcyc[k-1] == 40, "R3 staged no effect", pcyc[k] - pcyc[k-1], 40);
    end
    rd(8'h03, v); chk(v == 2, "R3 staged readback", v, 2);
    // R5 boundary: old length kept, new applies after
    load(0, 5, 50);
    wait_np(bi + 2);
    chk(pcyc[bi] - pcyc[bi-1] == 40, "R5 old cycle kept", pcyc[bi] - pcyc[bi-1], 40);
    chk(pcyc[bi+1] - pcyc[bi] == 50, "R5 new cycle", pcyc[bi+1] - pcyc[bi], 50);
    // R7 sweep
    for (int m = 2; m <= 6; m++)
      for (int f = 0; f < m; f++) begin
        load(f, m, 37);
        check_pattern(f, m, 37, f == 0 ? "R6 sweep" : "R7 sweep");
      end
    load(1, 2, 35);
    check_pattern(1, 2, 35, "R7 int min");
    load(1, 3, 4091);
    check_pattern(1, 3, 4091, "R7 int max");
    chk(cfg_error == 0, "R8 legal commits", cfg_error, 0);
    // R9 clamp
    load(9, 5, 40);
    chk(cfg_error == 1, "R8 frac over mod", cfg_error, 1);
    check_pattern(4, 5, 40, "R9 clamp");
    load(0, 5, 40);
    chk(cfg_error == 1, "R8 sticky", cfg_error, 1);
    // R8 each rule
    do_reset(); load(0, 1, 40);
    chk(cfg_error == 1, "R8 mod low", cfg_error, 1);
    do_reset(); load(0, 5, 34);
    chk(cfg_error == 1, "R8 int low", cfg_error, 1);
    do_reset(); load(0, 5, 4092);
    chk(cfg_error == 1, "R8 int high", cfg_error, 1);
    do_reset(); load(262142, 262143, 35);
    chk(cfg_error == 0, "R8 legal bounds", cfg_error, 0);
    // R10 pulse width
    g = np;
    wait_np(g + 1);
    @(negedge clk); #2;
    chk(div_pulse == 0, "R10 single cycle", div_pulse, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule